// File: doc/BRIEF.md
# Call and Vector Target Sequencer

This block works out the next program counter value whenever control flow leaves the normal instruction stream. Five kinds of transfer are supported: reset, a hardware interrupt, a software break, a one-byte table call and a two-byte page call. A page call needs no memory access. The target is the operand byte placed inside the last 256-byte page of the address space. Every other kind reads a 16-bit target word from a vector slot near the top of program memory. It reads the low byte and then the high byte over a read-only memory port that has one cycle of latency.

The instruction decoder gives the block one request per transfer. The request carries a kind code, the opcode or operand byte, and an interrupt source index. The block answers with the new PC and a done strobe that lasts one cycle. Pushing the return address onto the stack is left to other logic.

Top module: `call_vector_seq`

## Requirements
- R1: While reset is active and just after it, `pc_out` is 0x0000, `done` is 0 and `mem_rd` is 0.
- R2: A page call (kind 4) with operand k loads `pc_out` with 0xFF00 + k and raises `done` at the first clock edge after the request. It issues no memory read.
- R3: A table call (kind 3) takes n from bits 7:4 of the opcode byte and fetches its vector word at 0xFFDE − 2n. For example, opcode 0x4A fetches at 0xFFD6.
- R4: A software break (kind 2) fetches its vector word at 0xFFDE, the same slot as table call 0.
- R5: A reset request (kind 0) fetches its vector word at 0xFFFE.
- R6: An interrupt request (kind 1) with source index i fetches at 0xFFE0 + 2i. Index 15 falls on 0xFFFE, the reset slot.
- R7: A vector fetch reads the even address in one cycle and the odd address in the next cycle. Memory data returns one cycle after the address is presented. `pc_out` becomes {byte at odd address, byte at even address}.
- R8: A vector request loads `pc_out` and raises `done` at the third clock edge after the edge that accepted it.
- R9: `done` stays high for exactly one cycle per completed request. `pc_out` holds its value at all other times.
- R10: A request that arrives while a vector fetch is in progress has no effect. Kind codes 5 to 7 also have no effect: no read, no `done`, and `pc_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted only when the block is idle |
| req_kind | input | 3 | 0 reset, 1 interrupt, 2 break, 3 table call, 4 page call |
| req_byte | input | 8 | Opcode byte (table call) or operand byte (page call) |
| irq_idx | input | 4 | Interrupt source index |
| mem_rd | output | 1 | Program memory read enable |
| mem_addr | output | 16 | Program memory byte address |
| mem_data | input | 8 | Read data, valid one cycle after the address |
| pc_out | output | 16 | New program counter |
| done | output | 1 | One-cycle strobe when `pc_out` has been loaded |

## Verification
A wrong slot computation shows up on `mem_addr` in the cycle straight after the request is accepted, before any data comes back. A byte-order or capture fault shows up only three cycles later, as a `pc_out` whose halves are swapped or stale. A sequencer that fails to return to idle, or that accepts a request while busy, shows up as a missing or extra `done` strobe, or as a changed `pc_out` one to four cycles after the request. The bench uses a memory model whose low and high bytes differ. This makes byte-order faults visible at `pc_out`.

// File: rtl/call_vector_seq.sv
module call_vector_seq #(
  parameter logic [15:0] RST_SLOT  = 16'hFFFE,
  parameter logic [15:0] IRQ_BASE  = 16'hFFE0,
  parameter logic [15:0] TBL_TOP   = 16'hFFDE,
  parameter logic [15:0] PAGE_BASE = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [7:0]  req_byte,
  input  logic [3:0]  irq_idx,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_data,
  output logic [15:0] pc_out,
  output logic        done
);

  localparam logic [2:0] K_RST = 3'd0, K_IRQ = 3'd1, K_BRK = 3'd2,
                         K_TCALL = 3'd3, K_PCALL = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} state_t;

  state_t      state;
  logic [15:0] vaddr, vsel;
  logic [7:0]  lo_byte;
  logic        take_vec, take_page;

  always_comb begin
    case (req_kind)
      K_RST:   vsel = RST_SLOT;
      K_IRQ:   vsel = IRQ_BASE + 16'({irq_idx, 1'b0});
      K_TCALL: vsel = TBL_TOP - 16'({req_byte[7:4], 1'b0});
      default: vsel = TBL_TOP;
    endcase
  end

  assign take_vec  = req_valid && state == S_IDLE && req_kind <= K_TCALL;
  assign take_page = req_valid && state == S_IDLE && req_kind == K_PCALL;
  assign mem_rd    = state == S_LO || state == S_HI;
  assign mem_addr  = state == S_HI ? {vaddr[15:1], 1'b1} : vaddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      vaddr   <= RST_SLOT;
      lo_byte <= '0;
      pc_out  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (take_vec) begin
            vaddr <= {vsel[15:1], 1'b0};
            state <= S_LO;
          end else if (take_page) begin
            pc_out <= PAGE_BASE + 16'(req_byte);
            done   <= 1'b1;
          end
        end
        S_LO:  state <= S_HI;
        S_HI: begin
          lo_byte <= mem_data;
          state   <= S_FIN;
        end
        S_FIN: begin
          pc_out <= {mem_data, lo_byte};
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: the odd-address read follows the even one on the next cycle
  a_r7_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_addr[0]) |=> (mem_rd && mem_addr == $past(mem_addr) + 16'd1));

  // R8: done arrives two edges after the high-byte read
  a_r8_done_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr[0]) |=> (!mem_rd ##1 done));

  // R9: pc_out moves only together with done
  a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc_out));

  // R9: no read is in flight when done is raised
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);

  // R3 to R6: every vector read stays inside the top 64 bytes
  a_r6_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[15:6] == 10'h3FF);

endmodule

// File: tb/call_vector_seq_bench.sv
`timescale 1ns/1ps
module call_vector_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [7:0]  req_byte = '0;
  logic [3:0]  irq_idx = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic [15:0] pc_out;
  logic        done;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] model_pc = '0;

  always #2.5 clk = ~clk;

  call_vector_seq u_call_vector_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_byte(req_byte), .irq_idx(irq_idx), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .pc_out(pc_out), .done(done));

  function automatic logic [7:0] rom(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ 8'hC3;
  endfunction

  always @(posedge clk) mem_data <= rom(mem_addr);

  function automatic logic [15:0] slot(input logic [2:0] k, input logic [7:0] b,
                                       input logic [3:0] ix);
    case (k)
      3'd0: return 16'hFFFE;
      3'd1: return 16'hFFE0 + 16'(ix) * 16'd2;
      3'd3: return 16'hFFDE - 16'(b >> 4) * 16'd2;
      default: return 16'hFFDE;
    endcase
  endfunction

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] k, input logic [7:0] b,
                         input logic [3:0] ix, input bit intrude);
    logic [15:0] v, want;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_byte = b; irq_idx = ix;
    @(negedge clk);
    req_valid = 1'b0;
    if (k == 3'd4) begin
      want = 16'hFF00 + 16'(b);
      chk(done === 1'b1, "R2 done", 32'(done), 1);
      chk(pc_out === want, "R2 pc", 32'(pc_out), 32'(want));
      chk(mem_rd === 1'b0, "R2 no read", 32'(mem_rd), 0);
      model_pc = want;
      @(negedge clk);
      chk(done === 1'b0 && pc_out === model_pc, "R9 single pulse", 32'({done, pc_out}),
          32'({1'b0, model_pc}));
    end else if (k > 3'd4) begin
      chk(done === 1'b0 && mem_rd === 1'b0 && pc_out === model_pc, "R10 bad kind",
          32'({done, mem_rd, pc_out}), 32'({2'b00, model_pc}));
    end else begin
      v = slot(k, b, ix);
      chk(mem_rd === 1'b1 && mem_addr === v, kind_tag(k), 32'({mem_rd, mem_addr}),
          32'({1'b1, v}));
      if (intrude) begin
        req_valid = 1'b1; req_kind = 3'd4; req_byte = 8'h11;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_rd === 1'b1 && mem_addr === v + 16'd1, "R7 high read",
          32'({mem_rd, mem_addr}), 32'({1'b1, v + 16'd1}));
      @(negedge clk);
      chk(mem_rd === 1'b0 && done === 1'b0 && pc_out === model_pc,
          intrude ? "R10 busy" : "R8 wait", 32'({mem_rd, done, pc_out}),
          32'({2'b00, model_pc}));
      @(negedge clk);
      want = {rom(v + 16'd1), rom(v)};
      chk(done === 1'b1, "R8 done", 32'(done), 1);
      chk(pc_out === want, "R7 pc", 32'(pc_out), 32'(want));
      model_pc = want;
      @(negedge clk);
      chk(done === 1'b0 && pc_out === model_pc, "R9 single pulse", 32'({done, pc_out}),
          32'({1'b0, model_pc}));
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(pc_out === 16'h0 && done === 1'b0 && mem_rd === 1'b0, "R1 in reset",
        32'({done, mem_rd, pc_out}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc_out === 16'h0 && done === 1'b0 && mem_rd === 1'b0, "R1 after reset",
        32'({done, mem_rd, pc_out}), 0);
    run_req(3'd4, 8'h35, 4'd0, 0);   // R2: 0xFF35
    run_req(3'd4, 8'hBF, 4'd0, 0);   // R2: top of page area
    run_req(3'd3, 8'h4A, 4'd0, 0);   // R3: slot 0xFFD6
    run_req(3'd3, 8'h0A, 4'd0, 0);   // R3: table call 0
    run_req(3'd3, 8'hF0, 4'd0, 0);   // R3: table call 15 at 0xFFC0
    run_req(3'd2, 8'h00, 4'd0, 0);   // R4
    run_req(3'd0, 8'h00, 4'd0, 0);   // R5
    run_req(3'd1, 8'h00, 4'd0, 0);   // R6: 0xFFE0
    run_req(3'd1, 8'h00, 4'd14, 0);  // R6: 0xFFFC
    run_req(3'd1, 8'h00, 4'd15, 0);  // R6: reset slot
    run_req(3'd1, 8'h00, 4'd5, 1);   // R10: request during fetch
    run_req(3'd5, 8'h12, 4'd0, 0);   // R10
    run_req(3'd7, 8'h34, 4'd0, 0);   // R10
    for (int i = 0; i < 400; i++) begin
      run_req(3'($urandom_range(0, 6)), 8'($urandom), 4'($urandom),
              1'($urandom_range(0, 3) == 0));
    end
    finish_run();
  end
endmodule